// File: doc/BRIEF.md
# Compare-Match Toggle Output Channel

This block is one channel of a timer's capture/compare unit. A free-running timebase counter outside the block supplies its value together with an increment strobe. When the channel is armed and the counter reaches the programmed compare value, the channel inverts a dedicated output pin. It also raises a sticky match flag that software must clear, and an interrupt request that follows the flag while interrupts are enabled.

Software programs the channel through a narrow byte-wide register port. The compare value is written one byte at a time. A write to the lowest compare byte disarms the channel, and a write to the highest compare byte arms it again. Because of this, a 16-bit compare update made low byte first cannot cause a toggle on a half-written value. A separate mode register holds the compare-enable, match-enable, toggle-enable and interrupt-enable bits, and a status register exposes the flag.

Top module: `cmt_channel`

## Requirements
- R1: After a synchronous reset, the output pin is 0, the flag is 0, the interrupt request is 0, both compare bytes read 0x00, and the mode register reads 0x00.
- R2: With compare enable, match enable and toggle enable all 1, the pin inverts at the clock edge that ends a cycle in which the strobe is 1 and the counter equals the compare value. Nonmatching strobed values leave the pin unchanged.
- R3: A counter value that equals the compare value while the strobe is 0 causes no toggle and no flag, however many cycles it is held.
- R4: While compare enable is 0, a strobed match leaves the pin at its level and does not set the flag.
- R5: A strobed match with compare enable and match enable both 1 sets the flag (status bit 0), also when toggle enable is 0. In that case the pin does not change.
- R6: The flag stays 1 until software writes status bit 0 with 0. Writing status bit 0 with 1 has no effect.
- R7: If a flag-clearing write and a flag-setting match fall in the same cycle, the flag remains 1.
- R8: The interrupt request is 1 exactly while the flag is 1 and interrupt enable (mode bit 0) is 1.
- R9: A write to compare address 0 forces compare enable (mode bit 3) to 0. A write to compare address 1 forces it to 1. The other mode bits keep their values.
- R10: After the low byte of a new compare value is written and before the high byte is, a strobed match on the partly updated value does not toggle the pin.
- R11: The register map is as follows. Address 0 is the compare low byte and address 1 is the compare high byte. Address 2 is the mode register: bit 0 interrupt enable, bit 1 toggle enable, bit 2 match enable, bit 3 compare enable. Address 3 is the status register, with the flag at bit 0. Reads are combinational from the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 16 | Current timebase counter value |
| tb_tick | input | 1 | Counter increment strobe; qualifies the comparison |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| pin_out | output | 1 | Toggled output pin |
| irq | output | 1 | Interrupt request |

## Verification
Every result is due one clock edge after its cause. The pin and flag follow a strobed match, the register and arming effects follow a write, and the interrupt request follows the flag in the same cycle. The bench drives stimulus just after a falling edge and holds it across exactly one rising edge. It then samples the pin, the interrupt request and the combinational read data at the next falling edge, so each check sees the state after that single edge. The stall checks hold an equal counter value without a strobe over several edges and compare the pin after each one.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Mode bits, packed so that bit 0 is irq_en and bit 3 is cmp_en.
    typedef struct packed {
        logic cmp_en;
        logic match_en;
        logic toggle_en;
        logic irq_en;
    } cmt_mode_t;

    localparam int unsigned MODE_W = 4;

    // Outcome of one comparison cycle.
    typedef struct packed {
        logic hit;
        logic set_flag;
        logic do_toggle;
    } cmt_event_t;

    // Address of the mode register given the number of compare bytes.
    function automatic int unsigned mode_addr(input int unsigned nbytes);
        return nbytes;
    endfunction

    // Address of the status register given the number of compare bytes.
    function automatic int unsigned status_addr(input int unsigned nbytes);
        return nbytes + 1;
    endfunction

    // The channel may set its flag only when compare and match enables are both on.
    function automatic logic flag_allowed(input cmt_mode_t m);
        return m.cmp_en & m.match_en;
    endfunction

    // The pin may toggle only when all three output controls are on.
    function automatic logic toggle_allowed(input cmt_mode_t m);
        return m.cmp_en & m.match_en & m.toggle_en;
    endfunction

endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag_q,
    output logic [CNT_W-1:0]  cmp_q,
    output cmt_mode_t         mode_q,
    output logic              flag_clr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int unsigned NBYTES   = CNT_W / BYTE_W;
    localparam int unsigned TOP_BYTE = NBYTES - 1;
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(mode_addr(NBYTES));
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(status_addr(NBYTES));
    localparam logic [ADDR_W-1:0] A_LOW  = '0;
    localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(TOP_BYTE);

    logic wr_mode, wr_stat, wr_low, wr_high;

    assign wr_mode = wr_en && (wr_addr == A_MODE);
    assign wr_stat = wr_en && (wr_addr == A_STAT);
    assign wr_low  = wr_en && (wr_addr == A_LOW);
    assign wr_high = wr_en && (wr_addr == A_HIGH);

    // Writing 0 to status bit 0 requests a flag clear; writing 1 does nothing.
    assign flag_clr = wr_stat && !wr_data[0];

    // One byte register per compare byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(b))) begin
                byte_q <= wr_data;
            end
        end

        assign cmp_q[b*BYTE_W +: BYTE_W] = byte_q;
    end

    // Mode register: direct writes, plus arming side effects of compare writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= cmt_mode_t'(wr_data[MODE_W-1:0]);
        end else if (wr_low) begin
            mode_q.cmp_en <= 1'b0;
        end else if (wr_high) begin
            mode_q.cmp_en <= 1'b1;
        end
    end

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_MODE) begin
            rd_data[MODE_W-1:0] = mode_q;
        end else if (rd_addr == A_STAT) begin
            rd_data[0] = flag_q;
        end else begin
            for (int unsigned i = 0; i < NBYTES; i++) begin
                if (rd_addr == ADDR_W'(i)) begin
                    rd_data = cmp_q[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

endmodule

// File: rtl/cmt_match.sv
module cmt_match
    import cmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             tb_tick,
    input  logic [CNT_W-1:0] tb_count,
    input  logic [CNT_W-1:0] cmp_q,
    input  cmt_mode_t        mode_q,
    output cmt_event_t       ev
);

    // A match counts once per counter value: only on the increment strobe.
    always_comb begin
        ev.hit       = tb_tick && (tb_count == cmp_q);
        ev.set_flag  = ev.hit && flag_allowed(mode_q);
        ev.do_toggle = ev.hit && toggle_allowed(mode_q);
    end

endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_flag,
    input  logic clr_flag,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);

    // The set takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_flag) begin
            flag_q <= 1'b1;
        end else if (clr_flag) begin
            flag_q <= 1'b0;
        end
    end

    assign irq = flag_q & irq_en;

endmodule

// File: rtl/cmt_pin.sv
module cmt_pin (
    input  logic clk,
    input  logic rst,
    input  logic do_toggle,
    output logic pin_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (do_toggle) begin
            pin_q <= ~pin_q;
        end
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              tb_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              pin_out,
    output logic              irq
);

    logic [CNT_W-1:0] cmp_q;
    cmt_mode_t        mode_q;
    cmt_event_t       ev;
    logic             flag_q;
    logic             flag_clr;

    cmt_regs #(
        .CNT_W (CNT_W),
        .BYTE_W(BYTE_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flag_q  (flag_q),
        .cmp_q   (cmp_q),
        .mode_q  (mode_q),
        .flag_clr(flag_clr),
        .rd_data (rd_data)
    );

    cmt_match #(
        .CNT_W(CNT_W)
    ) u_match (
        .tb_tick (tb_tick),
        .tb_count(tb_count),
        .cmp_q   (cmp_q),
        .mode_q  (mode_q),
        .ev      (ev)
    );

    cmt_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_flag(ev.set_flag),
        .clr_flag(flag_clr),
        .irq_en  (mode_q.irq_en),
        .flag_q  (flag_q),
        .irq     (irq)
    );

    cmt_pin u_pin (
        .clk      (clk),
        .rst      (rst),
        .do_toggle(ev.do_toggle),
        .pin_q    (pin_out)
    );

endmodule

// File: rtl/cmt_channel_checker.sv
module cmt_channel_checker
    import cmt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  tb_count,
    input logic              tb_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              pin_out,
    input logic              irq,
    input logic              flag_q,
    input logic [CNT_W-1:0]  cmp_q,
    input cmt_mode_t         mode_q
);

    localparam int unsigned NBYTES = CNT_W / BYTE_W;
    localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(NBYTES - 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(status_addr(NBYTES));

    logic armed_hit;
    assign armed_hit = tb_tick && (tb_count == cmp_q)
                       && mode_q.cmp_en && mode_q.match_en && mode_q.toggle_en;

    AST_PIN_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        armed_hit |=> (pin_out != $past(pin_out)));                    // R2

    AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !armed_hit |=> $stable(pin_out));                              // R4

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !tb_tick |=> $stable(pin_out));                                // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !(wr_en && wr_addr == A_STAT && !wr_data[0])) |=> flag_q); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q);                                               // R8

    AST_LOW_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> !mode_q.cmp_en);                 // R9

    AST_HIGH_ARMS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_HIGH) |=> mode_q.cmp_en);              // R9

endmodule

bind cmt_channel cmt_channel_checker #(
    .CNT_W (CNT_W),
    .BYTE_W(BYTE_W),
    .ADDR_W(ADDR_W)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .tb_count(tb_count),
    .tb_tick (tb_tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pin_out (pin_out),
    .irq     (irq),
    .flag_q  (flag_q),
    .cmp_q   (cmp_q),
    .mode_q  (mode_q)
);

// File: tb/cmt_channel_bench.sv
module cmt_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tb_count = '0;
    logic        tb_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        pin_out;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic exp_pin = 1'b0;

    always #10 clk = ~clk;

    cmt_channel u_cmt_channel (
        .clk     (clk),
        .rst     (rst),
        .tb_count(tb_count),
        .tb_tick (tb_tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pin_out (pin_out),
        .irq     (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Write one register; state is updated when the task returns.
    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // One strobed counter value across one rising edge.
    task automatic tick(input logic [15:0] c);
        tb_count = c; tb_tick = 1'b1;
        @(negedge clk);
        tb_tick = 1'b0;
    endtask

    task automatic read_flag(output logic f);
        logic [7:0] d;
        reg_rd(2'd3, d);
        f = d[0];
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pin", pin_out, 0);
        chk("R1 irq", irq, 0);
        reg_rd(2'd0, d); chk("R1 low byte", d, 0);
        reg_rd(2'd1, d); chk("R1 high byte", d, 0);
        reg_rd(2'd2, d); chk("R1 mode", d, 0);
        reg_rd(2'd3, d); chk("R1 flag", d, 0);
    endtask

    task automatic t_arming();
        logic [7:0] d;
        reg_wr(2'd2, 8'h0E);
        reg_rd(2'd2, d); chk("R11 mode readback", d, 8'h0E);
        reg_wr(2'd0, 8'h34);
        reg_rd(2'd2, d); chk("R9 low write disarms", d, 8'h06);
        reg_rd(2'd0, d); chk("R11 low byte", d, 8'h34);
        reg_wr(2'd1, 8'h12);
        reg_rd(2'd2, d); chk("R9 high write arms", d, 8'h0E);
        reg_rd(2'd1, d); chk("R11 high byte", d, 8'h12);
    endtask

    task automatic t_toggle();
        logic f;
        tick(16'h1233); chk("R2 no match no toggle", pin_out, exp_pin);
        tick(16'h1234); exp_pin = ~exp_pin;
        chk("R2 toggle on match", pin_out, exp_pin);
        read_flag(f); chk("R5 flag set", f, 1);
        chk("R8 irq off while disabled", irq, 0);
        tick(16'h1235); chk("R2 hold after match", pin_out, exp_pin);
        tick(16'h1234); exp_pin = ~exp_pin;
        chk("R2 second toggle", pin_out, exp_pin);
    endtask

    task automatic t_stall();
        tb_count = 16'h1234; tb_tick = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R3 stalled counter no toggle", pin_out, exp_pin);
        end
    endtask

    task automatic t_clear();
        logic f;
        reg_wr(2'd3, 8'h01);
        read_flag(f); chk("R6 write 1 keeps flag", f, 1);
        @(negedge clk);
        read_flag(f); chk("R6 flag sticky", f, 1);
        reg_wr(2'd3, 8'h00);
        read_flag(f); chk("R6 write 0 clears", f, 0);
        t_stall_flag();
    endtask

    task automatic t_stall_flag();
        logic f;
        tb_count = 16'h1234; tb_tick = 1'b0;
        @(negedge clk);
        read_flag(f); chk("R3 no flag without strobe", f, 0);
    endtask

    task automatic t_irq();
        logic f;
        reg_wr(2'd2, 8'h0F);
        chk("R8 irq low while flag clear", irq, 0);
        tick(16'h1234); exp_pin = ~exp_pin;
        chk("R8 irq with flag and enable", irq, 1);
        reg_wr(2'd2, 8'h0E);
        chk("R8 irq drops with enable", irq, 0);
        read_flag(f); chk("R8 flag unchanged", f, 1);
        reg_wr(2'd2, 8'h0F);
        reg_wr(2'd3, 8'h00);
        chk("R8 irq drops with flag", irq, 0);
    endtask

    task automatic t_disabled();
        logic f;
        reg_wr(2'd2, 8'h06);
        tick(16'h1234);
        chk("R4 pin holds when disabled", pin_out, exp_pin);
        read_flag(f); chk("R4 no flag when disabled", f, 0);
    endtask

    task automatic t_flag_only();
        logic f;
        reg_wr(2'd2, 8'h0C);
        tick(16'h1234);
        chk("R5 no toggle with toggle off", pin_out, exp_pin);
        read_flag(f); chk("R5 flag with toggle off", f, 1);
    endtask

    task automatic t_race();
        logic f;
        // flag is 1 here; clear and match in the same cycle
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
        tb_count = 16'h1234; tb_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tb_tick = 1'b0;
        read_flag(f); chk("R7 set wins over clear", f, 1);
        reg_wr(2'd3, 8'h00);
        read_flag(f); chk("R7 later clear works", f, 0);
    endtask

    task automatic t_atomic();
        logic f;
        reg_wr(2'd2, 8'h0E);
        reg_wr(2'd0, 8'h00);
        tick(16'h1200);
        chk("R10 half-written value no toggle", pin_out, exp_pin);
        read_flag(f); chk("R10 half-written value no flag", f, 0);
        reg_wr(2'd1, 8'h56);
        tick(16'h1200);
        chk("R10 old value no toggle", pin_out, exp_pin);
        tick(16'h5600); exp_pin = ~exp_pin;
        chk("R10 new value toggles", pin_out, exp_pin);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_arming();
        t_toggle();
        t_stall();
        t_clear();
        t_irq();
        t_disabled();
        t_flag_only();
        t_race();
        t_atomic();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule